// File: doc/BRIEF.md
# Predictive Candidate Cost Evaluator

This block scores one switching candidate of a nine-level, single-DC-source inverter for a finite-set predictive controller. Each clock it may accept one 8-bit switch vector together with the sampled DC-link voltage, flying-capacitor voltage, grid voltage, grid current and the two references for the current control step. From the switch bits it forms signed multipliers for the DC-link voltage, the capacitor voltage and the capacitor current. A forward-Euler model uses them to predict the capacitor voltage and the grid current one sample ahead. Each candidate gets a weighted sum of squared tracking errors as its cost.

The datapath is a three-stage pipeline. A controller streams the sixteen legal vectors back to back and gets sixteen costs, each tagged with the index it supplied. All quantities share one signed fixed-point scale, for example 1/64 V or 1/64 A per LSB. The model gains (sample period over capacitance, and sample period over inductance) are parameters scaled by a power-of-two shift. The cost saturates at the top of its range and never wraps. Choosing the winning candidate is left to the caller.

Top module: `mpc_cand_cost`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_idx` and `out_cost` are all zero.
- R2: Switch bit `sw[7]` is s1 and `sw[0]` is s8. The output level is VAB = (s1 − s2 − s8)·V1 + (s2 − s3 + s7)·V2, where V1 is `v_dc` and V2 is `v_cap`. Example: 8'b10000110 gives V1+V2, 8'b10101000 gives V1−V2 and 8'b00110001 gives −(V1+V2).
- R3: The predicted grid current is ig + ((KI·(VAB − vg)) >>> KSH), using arithmetic (floor) shift.
- R4: The predicted capacitor voltage is V2 + ((KV·(s3 − s2 − s7)·ig) >>> KSH), using arithmetic shift.
- R5: The cost is WGT_V·(v_ref − V2next)² + WGT_I·(i_ref − ig_next)². The references are the ones sampled with the candidate. The default weights are 5 and 10.
- R6: A cost above 2^CW − 1 is reported as 2^CW − 1.
- R7: Each accepted candidate produces exactly one result, exactly 3 clock cycles after the `in_valid` cycle. Candidates may arrive on every clock with no gap, and results keep their input order.
- R8: `out_idx` equals the `cand_idx` that was presented with the candidate.
- R9: In any cycle where `out_valid` is low, `out_cost` and `out_idx` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Candidate strobe |
| cand_idx | input | 4 | Caller's tag for the candidate |
| sw | input | 8 | Switch vector, s1 in bit 7 down to s8 in bit 0 |
| v_dc | input | W | Signed DC-link voltage |
| v_cap | input | W | Signed capacitor voltage |
| v_grid | input | W | Signed grid voltage |
| i_grid | input | W | Signed grid current |
| i_ref | input | W | Signed grid-current reference |
| v_ref | input | W | Signed capacitor-voltage reference |
| out_valid | output | 1 | Result strobe |
| out_idx | output | 4 | Tag of the scored candidate |
| out_cost | output | CW | Unsigned saturating cost |

## Verification
All sixteen legal vectors are streamed at several operating points, and the expected costs are computed with wide integer arithmetic.

- **Zero grid current with the reference equal to the capacitor voltage.** The capacitor term drops out, which exposes the level decode and the current model on their own.
- **Nominal operating point.** A 150/50 split with a sag or swell in grid voltage exercises both error terms together.
- **Pseudo-random points.** Mixed-sign values exercise floor rounding of the shifts and sign handling.
- **Extreme references.** These drive the cost past its range to check saturation.

Gaps between bursts separate back-to-back throughput from hold behaviour.

// File: rtl/mpc_cand_cost.sv
module mpc_cand_cost #(
  parameter int W     = 16,
  parameter int KB    = 17,
  parameter int KSH   = 16,
  parameter int KI    = 218,
  parameter int KV    = 524,
  parameter int WB    = 8,
  parameter int WGT_V = 5,
  parameter int WGT_I = 10,
  parameter int CW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [3:0]          cand_idx,
  input  logic [7:0]          sw,
  input  logic signed [W-1:0] v_dc,
  input  logic signed [W-1:0] v_cap,
  input  logic signed [W-1:0] v_grid,
  input  logic signed [W-1:0] i_grid,
  input  logic signed [W-1:0] i_ref,
  input  logic signed [W-1:0] v_ref,
  output logic                out_valid,
  output logic [3:0]          out_idx,
  output logic [CW-1:0]       out_cost
);
  localparam int LW  = W + 3;
  localparam int DW  = W + 4;
  localparam int CTW = W + 2;
  localparam int EW  = W + 6;
  localparam int PIW = DW + KB + 1;
  localparam int PVW = CTW + KB + 1;
  localparam int QW  = 2 * EW;
  localparam int SW  = QW + WB + 1;
  localparam logic signed [KB:0] KI_S = (KB+1)'(KI);
  localparam logic signed [KB:0] KV_S = (KB+1)'(KV);
  localparam logic [WB-1:0] WV_U = WB'(WGT_V);
  localparam logic [WB-1:0] WI_U = WB'(WGT_I);

  // stage 1: switch-bit coefficients, output level, capacitor current term
  logic signed [2:0] ca, cb, cc;
  assign ca = $signed({2'b00, sw[7]}) - $signed({2'b00, sw[6]}) - $signed({2'b00, sw[0]});
  assign cb = $signed({2'b00, sw[6]}) - $signed({2'b00, sw[5]}) + $signed({2'b00, sw[1]});
  assign cc = $signed({2'b00, sw[5]}) - $signed({2'b00, sw[6]}) - $signed({2'b00, sw[1]});

  logic signed [LW-1:0] vab_c;
  logic signed [CTW-1:0] ct_c;
  assign vab_c = LW'(ca) * LW'(v_dc) + LW'(cb) * LW'(v_cap);
  assign ct_c  = CTW'(cc) * CTW'(i_grid);

  logic                  vld1;
  logic [3:0]            idx1;
  logic signed [LW-1:0]  vab1;
  logic signed [CTW-1:0] ct1;
  logic signed [W-1:0]   vg1, ig1, vc1, ir1, vr1;

  // stage 2: one-step predictions and tracking errors
  logic signed [DW-1:0]  dif;
  logic signed [PIW-1:0] pi;
  logic signed [PVW-1:0] pv;
  logic signed [EW-1:0]  inext, vnext, ev_c, ei_c;
  assign dif   = DW'(vab1) - DW'(vg1);
  assign pi    = PIW'(KI_S) * PIW'(dif);
  assign pv    = PVW'(KV_S) * PVW'(ct1);
  assign inext = EW'(ig1) + EW'(pi >>> KSH);
  assign vnext = EW'(vc1) + EW'(pv >>> KSH);
  assign ev_c  = EW'(vr1) - vnext;
  assign ei_c  = EW'(ir1) - inext;

  logic                 vld2;
  logic [3:0]           idx2;
  logic signed [EW-1:0] ev2, ei2;

  // stage 3: weighted squares, saturation
  logic signed [QW-1:0] sqv_s, sqi_s;
  logic [SW-1:0]        tot;
  logic [CW-1:0]        cost_c;
  assign sqv_s  = QW'(ev2) * QW'(ev2);
  assign sqi_s  = QW'(ei2) * QW'(ei2);
  assign tot    = SW'(WV_U) * SW'($unsigned(sqv_s)) + SW'(WI_U) * SW'($unsigned(sqi_s));
  assign cost_c = (|tot[SW-1:CW]) ? {CW{1'b1}} : tot[CW-1:0];

  always_ff @(posedge clk) begin
    idx1 <= cand_idx;
    vab1 <= vab_c;
    ct1  <= ct_c;
    vg1  <= v_grid;
    ig1  <= i_grid;
    vc1  <= v_cap;
    ir1  <= i_ref;
    vr1  <= v_ref;
    idx2 <= idx1;
    ev2  <= ev_c;
    ei2  <= ei_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1      <= 1'b0;
      vld2      <= 1'b0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_cost  <= '0;
    end else begin
      vld1      <= in_valid;
      vld2      <= vld1;
      out_valid <= vld2;
      if (vld2) begin
        out_idx  <= idx2;
        out_cost <= cost_c;
      end
    end
  end
endmodule

// File: rtl/mpc_cand_cost_chk.sv
module mpc_cand_cost_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    cand_idx,
  input logic          out_valid,
  input logic [3:0]    out_idx,
  input logic [CW-1:0] out_cost
);
  logic [1:0] cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= 2'd0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_cost == '0 && out_idx == 4'd0));

  a_r7_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r8_index_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && out_valid) |-> (out_idx == $past(cand_idx, 3)));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && !out_valid) |-> ($stable(out_cost) && $stable(out_idx)));
endmodule

bind mpc_cand_cost mpc_cand_cost_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cand_idx(cand_idx),
  .out_valid(out_valid), .out_idx(out_idx), .out_cost(out_cost)
);

// File: tb/tb_mpc_cand_cost.sv
module tb_mpc_cand_cost;
  localparam int W = 16, KSH = 16, KI = 218, KV = 524, CW = 32;
  localparam longint WV = 5, WI = 10;
  localparam longint CMAX = (64'sd1 <<< CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [3:0] cand_idx = '0;
  logic [7:0] sw = '0;
  logic signed [W-1:0] v_dc = '0, v_cap = '0, v_grid = '0, i_grid = '0, i_ref = '0, v_ref = '0;
  logic out_valid;
  logic [3:0] out_idx;
  logic [CW-1:0] out_cost;

  mpc_cand_cost dut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, wr = 0, rd = 0;
  bit done = 0;
  longint exp_c [1024];
  logic [3:0] exp_i [1024];
  int exp_t [1024];
  string exp_s [1024];
  logic [CW-1:0] last_cost = '0;
  logic [3:0] last_idx = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] cand(input int k);
    case (k)
      0: return 8'b10000110;  1: return 8'b10001100;
      2: return 8'b10100010;  3: return 8'b10101000;
      4: return 8'b00010110;  5: return 8'b11000100;
      6: return 8'b00110010;  7: return 8'b11100000;
      8: return 8'b00011100;  9: return 8'b10000101;
      10: return 8'b00111000; 11: return 8'b10100001;
      12: return 8'b01010100; 13: return 8'b00010101;
      14: return 8'b01110000; default: return 8'b00110001;
    endcase
  endfunction

  function automatic longint model(input logic [7:0] s, input longint v1, v2, vg, ig, ir, vr);
    longint a, b, c, vab, inx, vnx, ev, ei, cost;
    a = longint'(s[7]) - longint'(s[6]) - longint'(s[0]);
    b = longint'(s[6]) - longint'(s[5]) + longint'(s[1]);
    c = longint'(s[5]) - longint'(s[6]) - longint'(s[1]);
    vab = a * v1 + b * v2;
    inx = ig + ((longint'(KI) * (vab - vg)) >>> KSH);
    vnx = v2 + ((longint'(KV) * c * ig) >>> KSH);
    ev = vr - vnx;
    ei = ir - inx;
    cost = WV * ev * ev + WI * ei * ei;
    return (cost > CMAX) ? CMAX : cost;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd >= wr) chk("R7 unexpected result", 1, 0);
      else begin
        chk({exp_s[rd], " cost"}, longint'(out_cost), exp_c[rd]);
        chk("R8 index", longint'(out_idx), longint'(exp_i[rd]));
        chk("R7 latency", longint'(cyc - exp_t[rd]), 3);
        rd++;
      end
      last_cost = out_cost;
      last_idx = out_idx;
    end
  end

  task automatic burst(input string tag, input longint v1, v2, vg, ig, ir, vr);
    for (int k = 0; k < 16; k++) begin
      sw = cand(k); cand_idx = 4'(15 - k);
      v_dc = W'(v1); v_cap = W'(v2); v_grid = W'(vg);
      i_grid = W'(ig); i_ref = W'(ir); v_ref = W'(vr);
      in_valid = 1'b1;
      exp_c[wr] = model(sw, v1, v2, vg, ig, ir, vr);
      exp_i[wr] = cand_idx; exp_t[wr] = cyc; exp_s[wr] = tag;
      wr++;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", longint'(out_valid), 0);
    chk("R1 reset cost", longint'(out_cost), 0);
    chk("R1 reset idx", longint'(out_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2/R3: no grid current, reference equal to capacitor voltage
    burst("R2/R3 level decode", 9600, 3200, 0, 0, 0, 3200);
    burst("R2/R3 level decode sag", 9600, 3200, 9792, 0, 320, 3200);
    @(negedge clk);
    // R4/R5 nominal with current flowing, back to back
    burst("R4/R5 nominal", 9600, 3200, 10880, 320, 300, 3200);
    burst("R4/R5 swell", 9600, 3000, 11840, -320, -300, 3200);
    burst("R4/R5 large step", 13440, 4480, -10880, 640, 500, 4480);
    for (int p = 0; p < 8; p++) begin
      longint q[6];
      for (int j = 0; j < 6; j++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        q[j] = longint'($signed(lf)) / 4;
      end
      burst("R3/R4/R5 random", q[0], q[1], q[2], q[3], q[4], q[5]);
      if (p[0]) repeat (2) @(negedge clk);
    end
    // R6 saturation: huge errors
    burst("R6 saturate", 32767, -32768, -32768, 32767, -32768, 32767);
    burst("R6 saturate neg", -32768, 32767, 32767, -32768, 32767, -32768);
    repeat (6) @(negedge clk);
    chk("R7 all results", longint'(rd), longint'(wr));
    // R9: outputs hold while idle
    chk("R9 idle valid", longint'(out_valid), 0);
    chk("R9 idle cost hold", longint'(out_cost), longint'(last_cost));
    chk("R9 idle idx hold", longint'(out_idx), longint'(last_idx));
    repeat (4) @(negedge clk);
    chk("R9 idle cost hold later", longint'(out_cost), longint'(last_cost));
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule